// File: doc/BRIEF.md
# IR Frame Receive Status Tracker

This block sits between the byte output of a fast infrared receive decoder and the host. It holds received bytes in a small tagged FIFO. Every entry carries a marker bit that says whether it closes a frame, so that several frames waiting in the FIFO can still be told apart. Alongside the FIFO it maintains an 8-bit status word. That word shows whether data is waiting and whether the byte at the FIFO head ends a frame. It also holds sticky flags for frames that grew too long, illegal symbols, bad CRCs and lost bytes.

Each received byte is counted against a programmable 16-bit maximum frame length. A frame that goes past the limit is cut short: its last stored byte becomes the frame end, and later bytes are discarded until the decoder reports the frame end. An illegal symbol aborts the frame in the same way. When no stored byte can carry the end marker, a tagged zero byte is stored in its place. The transmit-side empty indications are not generated here. They are only sampled into the status word.

Top module: `irrx_frame_status`

## Requirements
- R1: After reset all eight status bits are 0 and the FIFO is empty.
- R2: Status bit 6 and bit 5 show `tx_shift_empty` and `tx_buf_empty`, each sampled one clock earlier.
- R3: Status bit 0 (data ready) is 1 exactly while the FIFO holds at least one entry. `pop` removes the head entry, and entries leave in the order they were stored, with `head_data` showing the head byte.
- R4: Status bit 7 is 1 when the head entry is tagged as the last byte of a frame. A byte received together with `in_frame_end` is stored with the tag set.
- R5: An `in_frame_end` strobe without a byte sets the tag on the most recently stored byte of the frame if that byte is still in the FIFO. If that byte has already left, a tagged 0x00 entry is stored instead. If the frame stored nothing, nothing is stored.
- R6: A byte that arrives when the frame already holds `max_len` received bytes sets status bit 4 and is discarded. The frame is then closed as in R5, and if it stored nothing a tagged 0x00 entry is stored. All further bytes are discarded until `in_frame_end`.
- R7: The received-byte count restarts at every frame end, so each frame is checked against the limit separately.
- R8: `in_sym_err` sets status bit 3 and discards any byte given in the same cycle. It closes the frame as in R6, including the tagged 0x00 entry when the frame stored nothing, and the next byte starts a new frame.
- R9: `in_crc_fail` sets status bit 2.
- R10: A byte that arrives while the FIFO holds 16 entries sets status bit 1 (overrun) and is discarded.
- R11: Status bits 4 to 1 stay set until a `stat_rd` strobe clears them. A new setting event in the same cycle as `stat_rd` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_byte_vld | input | 1 | A decoded byte is present |
| in_byte | input | 8 | Decoded byte |
| in_frame_end | input | 1 | Decoder frame-end strobe |
| in_sym_err | input | 1 | Illegal-symbol strobe |
| in_crc_fail | input | 1 | Strobe: frame CRC was wrong |
| max_len | input | 16 | Maximum bytes per frame |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| tx_buf_empty | input | 1 | Transmit buffer empty |
| pop | input | 1 | Remove the FIFO head entry |
| stat_rd | input | 1 | Host status read, clears sticky bits |
| status | output | 8 | Status word |
| head_data | output | 8 | Byte at the FIFO head |

## Verification
Frames are fed in four ways. The frame end can arrive with the last byte, or as a separate strobe while that byte is still stored. It can also arrive after that byte has been drained, and it can arrive with no bytes at all. Together these separate a direct tag, a retro-tag, a substitute zero entry and no entry. Length limits of 2 and 0 show the cut point and the zero-entry case. A following frame shows that the count restarts. Illegal symbols with and without stored bytes, a same-cycle byte on an illegal symbol, and a 17-byte burst into an undrained FIFO each end in a drain that compares every head byte and head tag against the expected queue.

// File: rtl/irrx_pkg.sv
package irrx_pkg;
    localparam int LEN_W = 16;

    typedef struct packed {
        logic [LEN_W-1:0] rx_cnt;
        logic             closed;
        logic             any_wr;
        logic             lex_err;
        logic             phy_err;
        logic             crc_err;
        logic             ovr_err;
        logic             txs;
        logic             txb;
    } frm_state_t;
endpackage

// File: rtl/irrx_tag_fifo.sv
module irrx_tag_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          push_tag,
    input  logic          retag,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic          head_tag,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [DW-1:0]    mem_q [DEPTH];
    logic [DEPTH-1:0] tag_q;
    logic             do_push, do_pop;
    logic [AW-1:0]    last_idx;

    function automatic logic [AW-1:0] inc(input logic [AW-1:0] v);
        return (v == AW'(DEPTH - 1)) ? '0 : v + 1'b1;
    endfunction

    always_comb begin
        p_d      = p_q;
        do_push  = push && (p_q.cnt != CW'(DEPTH));
        do_pop   = pop && (p_q.cnt != '0);
        last_idx = (p_q.wr == '0) ? AW'(DEPTH - 1) : p_q.wr - 1'b1;
        if (do_push) p_d.wr = inc(p_q.wr);
        if (do_pop)  p_d.rd = inc(p_q.rd);
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q   <= '0;
            tag_q <= '0;
        end else begin
            p_q <= p_d;
            if (do_push) tag_q[p_q.wr] <= push_tag;
            if (retag && p_q.cnt != '0) tag_q[last_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[p_q.wr] <= push_data;
    end

    assign head_data = mem_q[p_q.rd];
    assign head_tag  = tag_q[p_q.rd];
    assign count     = p_q.cnt;
endmodule

// File: rtl/irrx_frame_status.sv
module irrx_frame_status
    import irrx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_byte_vld,
    input  logic [7:0]       in_byte,
    input  logic             in_frame_end,
    input  logic             in_sym_err,
    input  logic             in_crc_fail,
    input  logic [LEN_W-1:0] max_len,
    input  logic             tx_shift_empty,
    input  logic             tx_buf_empty,
    input  logic             pop,
    input  logic             stat_rd,
    output logic [7:0]       status,
    output logic [7:0]       head_data
);
    frm_state_t s_d, s_q;
    logic          push, push_tag, retag, head_tag;
    logic [7:0]    push_data;
    logic [CW-1:0] fifo_cnt;
    logic          full, nonempty;
    logic          close, abort, reopen, can_retag;

    assign full     = (fifo_cnt == CW'(DEPTH));
    assign nonempty = (fifo_cnt != '0);

    always_comb begin
        s_d       = s_q;
        push      = 1'b0;
        push_tag  = 1'b0;
        push_data = in_byte;
        retag     = 1'b0;
        close     = 1'b0;
        abort     = 1'b0;
        reopen    = 1'b0;
        can_retag = 1'b0;
        s_d.txs   = tx_shift_empty;
        s_d.txb   = tx_buf_empty;

        if (stat_rd) begin
            s_d.lex_err = 1'b0;
            s_d.phy_err = 1'b0;
            s_d.crc_err = 1'b0;
            s_d.ovr_err = 1'b0;
        end
        if (in_crc_fail) s_d.crc_err = 1'b1;

        if (in_sym_err) begin
            s_d.phy_err = 1'b1;
            close       = 1'b1;
            abort       = 1'b1;
            reopen      = 1'b1;
        end else if (s_q.closed) begin
            reopen = in_frame_end;
        end else if (in_byte_vld && s_q.rx_cnt >= max_len) begin
            s_d.lex_err = 1'b1;
            s_d.closed  = 1'b1;
            close       = 1'b1;
            abort       = 1'b1;
            reopen      = in_frame_end;
        end else if (in_byte_vld) begin
            s_d.rx_cnt = s_q.rx_cnt + 1'b1;
            if (full) begin
                s_d.ovr_err = 1'b1;
                close       = in_frame_end;
            end else begin
                push       = 1'b1;
                push_tag   = in_frame_end;
                s_d.any_wr = 1'b1;
            end
            reopen = in_frame_end;
        end else if (in_frame_end) begin
            close  = 1'b1;
            reopen = 1'b1;
        end

        if (close) begin
            can_retag = s_q.any_wr && nonempty && !(pop && fifo_cnt == CW'(1));
            if (can_retag) begin
                retag = 1'b1;
            end else if (s_q.any_wr || abort) begin
                if (full) begin
                    s_d.ovr_err = 1'b1;
                end else begin
                    push      = 1'b1;
                    push_tag  = 1'b1;
                    push_data = '0;
                end
            end
        end

        if (reopen) begin
            s_d.rx_cnt = '0;
            s_d.any_wr = 1'b0;
            s_d.closed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    irrx_tag_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .push_tag  (push_tag),
        .retag     (retag),
        .pop       (pop),
        .head_data (head_data),
        .head_tag  (head_tag),
        .count     (fifo_cnt)
    );

    assign status = {head_tag & nonempty, s_q.txs, s_q.txb, s_q.lex_err,
                     s_q.phy_err, s_q.crc_err, s_q.ovr_err, nonempty};
endmodule

// File: rtl/irrx_frame_status_chk.sv
module irrx_frame_status_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_byte_vld,
    input logic          in_frame_end,
    input logic          in_sym_err,
    input logic          in_crc_fail,
    input logic          tx_shift_empty,
    input logic          stat_rd,
    input logic [7:0]    status,
    input logic [CW-1:0] fifo_cnt
);
    assert_crc_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_crc_fail |=> status[2]);

    assert_sym_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_sym_err |=> status[3]);

    assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] && !stat_rd |=> status[1]);

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !in_byte_vld && !in_sym_err && !in_crc_fail && !in_frame_end
        |=> status[4:1] == 4'b0000);

    assert_idle_stays_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !status[0] && !in_byte_vld && !in_frame_end && !in_sym_err |=> !status[0]);

    assert_tag_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status[7] |-> status[0]);

    assert_tx_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status[6] == $past(tx_shift_empty));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));
endmodule

bind irrx_frame_status irrx_frame_status_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_byte_vld    (in_byte_vld),
    .in_frame_end   (in_frame_end),
    .in_sym_err     (in_sym_err),
    .in_crc_fail    (in_crc_fail),
    .tx_shift_empty (tx_shift_empty),
    .stat_rd        (stat_rd),
    .status         (status),
    .fifo_cnt       (fifo_cnt)
);

// File: tb/sim_irrx_frame_status.sv
module sim_irrx_frame_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_byte_vld = 1'b0, in_frame_end = 1'b0, in_sym_err = 1'b0;
    logic        in_crc_fail = 1'b0, tx_shift_empty = 1'b0, tx_buf_empty = 1'b0;
    logic        pop = 1'b0, stat_rd = 1'b0;
    logic [7:0]  in_byte = '0;
    logic [15:0] max_len = 16'd100;
    logic [7:0]  status, head_data;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    logic [8:0] exp_q [$];

    always #5 clk = ~clk;

    irrx_frame_status u0 (
        .clk(clk), .rst_n(rst_n), .in_byte_vld(in_byte_vld), .in_byte(in_byte),
        .in_frame_end(in_frame_end), .in_sym_err(in_sym_err), .in_crc_fail(in_crc_fail),
        .max_len(max_len), .tx_shift_empty(tx_shift_empty), .tx_buf_empty(tx_buf_empty),
        .pop(pop), .stat_rd(stat_rd), .status(status), .head_data(head_data)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock of stimulus, starting and ending at a falling edge
    task automatic cyc(input logic v, input logic [7:0] b, input logic fe,
                       input logic se, input logic cf, input logic rd);
        in_byte_vld = v; in_byte = b; in_frame_end = fe;
        in_sym_err = se; in_crc_fail = cf; stat_rd = rd;
        @(negedge clk);
        in_byte_vld = 0; in_frame_end = 0; in_sym_err = 0; in_crc_fail = 0; stat_rd = 0;
    endtask

    task automatic rx(input logic [7:0] b, input logic fe);
        cyc(1, b, fe, 0, 0, 0);
    endtask

    task automatic expect_entry(input logic tag, input logic [7:0] b);
        exp_q.push_back({tag, b});
    endtask

    // monitor: pops every entry and compares it with the scoreboard
    task automatic drain(input string req);
        for (int n = 0; n < 40 && status[0]; n++) begin
            if (exp_q.size() == 0) check(req, {status[7], head_data}, 9'h1ff);
            else check(req, {status[7], head_data}, exp_q.pop_front());
            pop = 1;
            @(negedge clk);
            pop = 0;
        end
        check({req, " queue left"}, 9'(exp_q.size()), 9'd0);
        exp_q.delete();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset status", {1'b0, status}, 9'h000);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", {1'b0, status}, 9'h000);

        // R2: transmit flags sampled
        tx_shift_empty = 1; tx_buf_empty = 0;
        @(negedge clk);
        check("R2 tx bits", {7'd0, status[6], status[5]}, 9'b10);
        tx_shift_empty = 0; tx_buf_empty = 1;
        @(negedge clk);
        check("R2 tx bits swap", {7'd0, status[6], status[5]}, 9'b01);
        tx_buf_empty = 0;
        @(negedge clk);

        // R3 R4: end marker with last byte
        rx(8'h11, 0); rx(8'h22, 0); rx(8'h33, 1);
        expect_entry(0, 8'h11); expect_entry(0, 8'h22); expect_entry(1, 8'h33);
        check("R3 data ready", {8'd0, status[0]}, 9'd1);
        check("R4 head not last", {8'd0, status[7]}, 9'd0);
        drain("R3 R4 frame A");
        check("R3 empty after drain", {8'd0, status[0]}, 9'd0);

        // R5: separate end strobe retro-tags; two frames queued
        rx(8'h44, 0); rx(8'h55, 0); cyc(0, 0, 1, 0, 0, 0);
        rx(8'h66, 1);
        expect_entry(0, 8'h44); expect_entry(1, 8'h55); expect_entry(1, 8'h66);
        drain("R5 R4 retag two frames");

        // R5: last byte already gone -> zero entry; empty frame -> nothing
        rx(8'h77, 0);
        expect_entry(0, 8'h77);
        drain("R5 before end");
        cyc(0, 0, 1, 0, 0, 0);
        expect_entry(1, 8'h00);
        drain("R5 zero entry");
        cyc(0, 0, 1, 0, 0, 0);
        check("R5 empty frame no entry", {8'd0, status[0]}, 9'd0);

        // R6 R7: length limit 2
        max_len = 16'd2;
        rx(8'h01, 0); rx(8'h02, 0); rx(8'h03, 0); rx(8'h04, 0);
        check("R6 lex bit", {8'd0, status[4]}, 9'd1);
        cyc(0, 0, 1, 0, 0, 0);
        rx(8'h05, 0); rx(8'h06, 1);
        expect_entry(0, 8'h01); expect_entry(1, 8'h02);
        expect_entry(0, 8'h05); expect_entry(1, 8'h06);
        drain("R6 R7 limit 2");
        check("R11 lex sticky", {8'd0, status[4]}, 9'd1);
        cyc(0, 0, 0, 0, 0, 1);
        check("R11 lex cleared", {8'd0, status[4]}, 9'd0);

        // R6: limit 0 -> zero entry
        max_len = 16'd0;
        rx(8'h09, 0);
        cyc(0, 0, 1, 0, 0, 0);
        expect_entry(1, 8'h00);
        check("R6 lex limit 0", {8'd0, status[4]}, 9'd1);
        drain("R6 limit 0");
        max_len = 16'd100;
        cyc(0, 0, 0, 0, 0, 1);

        // R8: illegal symbol
        rx(8'hA1, 0);
        cyc(1, 8'hA2, 0, 1, 0, 0);
        rx(8'hA3, 1);
        expect_entry(1, 8'hA1); expect_entry(1, 8'hA3);
        check("R8 phy bit", {8'd0, status[3]}, 9'd1);
        drain("R8 abort with byte");
        cyc(0, 0, 0, 1, 0, 0);
        expect_entry(1, 8'h00);
        drain("R8 abort empty");
        cyc(0, 0, 0, 0, 0, 1);
        check("R11 phy cleared", {8'd0, status[3]}, 9'd0);

        // R9 R11: crc
        cyc(0, 0, 0, 0, 1, 0);
        check("R9 crc bit", {8'd0, status[2]}, 9'd1);
        cyc(0, 0, 0, 0, 1, 1);
        check("R11 set wins over read", {8'd0, status[2]}, 9'd1);
        cyc(0, 0, 0, 0, 0, 1);
        check("R11 crc cleared", {8'd0, status[2]}, 9'd0);

        // R10: overrun at 16 entries
        for (int i = 0; i < 17; i++) rx(8'(8'h80 + i), 0);
        check("R10 overrun bit", {8'd0, status[1]}, 9'd1);
        cyc(0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 16; i++) expect_entry(i == 15, 8'(8'h80 + i));
        drain("R10 sixteen kept");
        check("R11 ovr sticky", {8'd0, status[1]}, 9'd1);
        cyc(0, 0, 0, 0, 0, 1);
        check("R11 all cleared", {1'b0, status}, 9'h000);

        finish_run();
    end
endmodule